// File: doc/BRIEF.md
# Indexed Memory Configuration Register Bank

This block puts a bank of byte-wide configuration registers behind two I/O ports. One port takes an index and the other moves data to or from the register that index selects. The host writes the index once and may then touch the selected register any number of times through the data port, because the index never advances by itself. With the default parameters the index port sits at I/O address 0x00E0, the data port at 0x00E1, and there are 256 registers.

Two of these registers also steer memory decode. For each incoming 20-bit memory address the block reports whether the access is claimed by on-board memory or passed on to the external bus. The low 512 KB and the 128 KB region just above it each have their own enable bit. Every address outside those two regions goes to the external bus.

Top module: `memcfg_bank`

## Requirements
- R1: A write strobe (io_wr=1) at io_addr 0x00E0 latches io_wdata as the register index at the next rising clock edge.
- R2: A write strobe at io_addr 0x00E1 stores io_wdata into the register the current index selects. No other register changes.
- R3: While io_rd=1 and io_addr=0x00E1, io_rdata combinationally shows the register the current index selects. For any other read address, and whenever io_rd=0, io_rdata is 0xFF.
- R4: For mem_addr 0x00000 to 0x7FFFF, mem_internal equals bit 0 of register 0 (1 means on-board memory, 0 means the external bus).
- R5: For mem_addr 0x80000 to 0x9FFFF, mem_internal equals bit 0 of register 1.
- R6: For mem_addr 0xA0000 and above, mem_internal is 0 whatever the registers hold.
- R7: After a data-port write, mem_internal reflects the new register contents from the first clock cycle after the write edge.
- R8: Reset (rst_n=0) clears the index and every register to 0x00, so both regions start on the external bus.
- R9: Data-port reads and writes leave the index unchanged, with no auto-increment.
- R10: Bits 7..1 of registers 0 and 1, and every bit of registers 2 to 255, have no effect on mem_internal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address for the current cycle |
| io_wr | input | 1 | I/O write strobe, one access per cycle |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0xFF when not selected |
| mem_addr | input | 20 | Memory address to be routed |
| mem_internal | output | 1 | 1 routes the access to on-board memory, 0 to the external bus |

## Verification
Random sequences mix index writes, data writes, data reads and reads of unrelated ports over the whole index range. A bench model of all 256 registers checks every readback, which separates a wrong index latch from a wrong write target. Route checks cover the exact region edges (0x7FFFF/0x80000, 0x9FFFF/0xA0000) and both enable bits in all four combinations, which exposes swapped or mis-sized regions. Directed cases write the upper bits of the control registers and fill unrelated registers with ones to show they leave routing alone. Back-to-back data accesses show that the index does not advance.

// File: rtl/memcfg_pkg.sv
package memcfg_pkg;
   typedef logic [7:0] cfg_byte_t;
   localparam int unsigned N_REGIONS = 2;
   localparam int unsigned ROUTE_BIT = 0;
endpackage

// File: rtl/memcfg_io_decode.sv
module memcfg_io_decode #(
   parameter int unsigned IO_AW    = 16,
   parameter int unsigned IDX_PORT = 16'h00E0,
   parameter int unsigned DAT_PORT = 16'h00E1
) (
   input  logic [IO_AW-1:0] io_addr,
   input  logic             io_wr,
   input  logic             io_rd,
   output logic             idx_we,
   output logic             dat_we,
   output logic             dat_re
);
   localparam logic [IO_AW-1:0] IDX_A = IO_AW'(IDX_PORT);
   localparam logic [IO_AW-1:0] DAT_A = IO_AW'(DAT_PORT);

   if (IDX_PORT == DAT_PORT) begin : g_bad_ports
      $error("index and data ports must differ");
   end

   always_comb begin
      idx_we = io_wr && (io_addr == IDX_A);
      dat_we = io_wr && (io_addr == DAT_A);
      dat_re = io_rd && (io_addr == DAT_A);
   end
endmodule

// File: rtl/memcfg_regfile.sv
module memcfg_regfile
   import memcfg_pkg::*;
#(
   parameter int unsigned NREG = 256,
   parameter int unsigned IDXW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idx_we,
   input  logic                 dat_we,
   input  cfg_byte_t            wdata,
   output cfg_byte_t            rd_val,
   output logic [N_REGIONS-1:0] route_en
);
   logic [IDXW-1:0] idx_q;
   cfg_byte_t       regs [NREG];

   always_ff @(posedge clk) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= wdata[IDXW-1:0];
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (dat_we && (idx_q == IDXW'(g)))
            regs[g] <= wdata;
      end
   end

   always_comb rd_val = regs[idx_q];

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_route
      always_comb route_en[r] = regs[r][ROUTE_BIT];
   end
endmodule

// File: rtl/memcfg_router.sv
module memcfg_router
   import memcfg_pkg::*;
#(
   parameter int unsigned AW       = 20,
   parameter int unsigned LOW_SIZE = 32'h8_0000,
   parameter int unsigned MID_SIZE = 32'h2_0000
) (
   input  logic [AW-1:0]        addr,
   input  logic [N_REGIONS-1:0] route_en,
   output logic                 internal
);
   localparam int unsigned EDGES [N_REGIONS+1] = '{0, LOW_SIZE, LOW_SIZE + MID_SIZE};
   logic [N_REGIONS-1:0] hit;

   for (genvar r = 0; r < N_REGIONS; r++) begin : g_win
      localparam logic [AW:0] LO = (AW+1)'(EDGES[r]);
      localparam logic [AW:0] HI = (AW+1)'(EDGES[r+1]);
      always_comb hit[r] = ({1'b0, addr} >= LO) && ({1'b0, addr} < HI) && route_en[r];
   end

   always_comb internal = |hit;
endmodule

// File: rtl/memcfg_bank.sv
module memcfg_bank
   import memcfg_pkg::*;
#(
   parameter int unsigned IO_AW    = 16,
   parameter int unsigned IDX_PORT = 16'h00E0,
   parameter int unsigned DAT_PORT = 16'h00E1,
   parameter int unsigned NREG     = 256,
   parameter int unsigned MEM_AW   = 20,
   parameter int unsigned LOW_SIZE = 32'h8_0000,
   parameter int unsigned MID_SIZE = 32'h2_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [MEM_AW-1:0] mem_addr,
   output logic              mem_internal
);
   localparam int unsigned IDXW = $clog2(NREG);

   if (NREG < N_REGIONS || NREG > 256 || (1 << IDXW) != NREG) begin : g_bad_nreg
      $error("NREG must be a power of two between region count and 256");
   end
   if (64'(LOW_SIZE) + 64'(MID_SIZE) > (64'd1 << MEM_AW)) begin : g_bad_map
      $error("regions exceed the memory address space");
   end

   logic                 idx_we, dat_we, dat_re;
   cfg_byte_t            rd_val;
   logic [N_REGIONS-1:0] route_en;

   memcfg_io_decode #(.IO_AW(IO_AW), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT)) u_dec (
      .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .idx_we(idx_we), .dat_we(dat_we), .dat_re(dat_re)
   );

   memcfg_regfile #(.NREG(NREG), .IDXW(IDXW)) u_rf (
      .clk(clk), .rst_n(rst_n), .idx_we(idx_we), .dat_we(dat_we),
      .wdata(io_wdata), .rd_val(rd_val), .route_en(route_en)
   );

   memcfg_router #(.AW(MEM_AW), .LOW_SIZE(LOW_SIZE), .MID_SIZE(MID_SIZE)) u_rt (
      .addr(mem_addr), .route_en(route_en), .internal(mem_internal)
   );

   always_comb io_rdata = dat_re ? rd_val : 8'hFF;
endmodule

// File: rtl/memcfg_bank_chk.sv
module memcfg_bank_chk #(
   parameter int unsigned IO_AW    = 16,
   parameter int unsigned DAT_PORT = 16'h00E1,
   parameter int unsigned MEM_AW   = 20,
   parameter int unsigned LOW_SIZE = 32'h8_0000,
   parameter int unsigned MID_SIZE = 32'h2_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [IO_AW-1:0]  io_addr,
   input logic              io_wr,
   input logic              io_rd,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic [MEM_AW-1:0] mem_addr,
   input logic              mem_internal
);
   localparam logic [IO_AW-1:0] DA  = IO_AW'(DAT_PORT);
   localparam logic [MEM_AW:0]  TOP = (MEM_AW+1)'(LOW_SIZE + MID_SIZE);

   // R2
   wr_then_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == DA) |=> ((io_rd && io_addr == DA) -> io_rdata == $past(io_wdata)));

   // R3
   idle_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_rd && io_addr == DA) |-> io_rdata == 8'hFF);

   // R6
   outside_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, mem_addr} >= TOP) |-> !mem_internal);

   // R9
   stable_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !io_wr && io_addr == DA) |=> ((io_rd && !io_wr && io_addr == DA) -> $stable(io_rdata)));

   // R8
   reset_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !mem_internal);
endmodule

bind memcfg_bank memcfg_bank_chk #(
   .IO_AW(IO_AW), .DAT_PORT(DAT_PORT), .MEM_AW(MEM_AW),
   .LOW_SIZE(LOW_SIZE), .MID_SIZE(MID_SIZE)
) u_chk (.*);

// File: tb/memcfg_bank_tb.sv
module memcfg_bank_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [15:0] io_addr = 16'h0000;
   logic        io_wr = 0, io_rd = 0;
   logic [7:0]  io_wdata = 0;
   logic [7:0]  io_rdata;
   logic [19:0] mem_addr = 0;
   logic        mem_internal;

   int total = 0, bad = 0;
   logic [7:0] m_reg [256];
   logic [7:0] m_idx;

   memcfg_bank u_dut (.*);

   always #5 clk = ~clk;

   function automatic logic exp_route(input logic [19:0] a);
      if (a < 20'h80000)      return m_reg[0][0];
      else if (a < 20'hA0000) return m_reg[1][0];
      else                    return 1'b0;
   endfunction

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr_idx(input logic [7:0] v);
      @(negedge clk); io_addr = 16'h00E0; io_wr = 1; io_wdata = v;
      @(posedge clk); #1 io_wr = 0; io_addr = 16'h0000; m_idx = v;
   endtask

   task automatic wr_dat(input logic [7:0] v);
      @(negedge clk); io_addr = 16'h00E1; io_wr = 1; io_wdata = v;
      @(posedge clk); #1 io_wr = 0; io_addr = 16'h0000; m_reg[m_idx] = v;
   endtask

   task automatic rd_port(input logic [15:0] a, input string tag);
      @(negedge clk); io_addr = a; io_rd = 1; #1;
      check8(tag, io_rdata, (a == 16'h00E1) ? m_reg[m_idx] : 8'hFF);
      @(posedge clk); #1 io_rd = 0; io_addr = 16'h0000;
   endtask

   task automatic chk_route(input logic [19:0] a, input string tag);
      @(negedge clk); mem_addr = a; #1;
      check8(tag, {7'd0, mem_internal}, {7'd0, exp_route(a)});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
      m_idx = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;

      // R8: reset state
      chk_route(20'h00000, "R8 low ext");
      chk_route(20'h80000, "R8 mid ext");
      rd_port(16'h00E1, "R8 reg0 zero");

      // R1, R2: write and read back
      wr_idx(8'h37); wr_dat(8'hA5); rd_port(16'h00E1, "R2 readback 37");
      wr_idx(8'hFF); wr_dat(8'h5A); rd_port(16'h00E1, "R1 index ff");
      wr_idx(8'h37); rd_port(16'h00E1, "R1 reselect 37");
      // R3: other ports
      rd_port(16'h00E0, "R3 index port ff");
      rd_port(16'h0092, "R3 other port ff");

      // R9: no auto-increment
      wr_idx(8'h10); wr_dat(8'h11); wr_dat(8'h22);
      rd_port(16'h00E1, "R9 same reg");
      wr_idx(8'h11); rd_port(16'h00E1, "R9 next untouched");

      // R4, R7: region 0
      wr_idx(8'h00); wr_dat(8'h01);
      chk_route(20'h7FFFF, "R7 low on after write");
      chk_route(20'h00000, "R4 low base");
      chk_route(20'h80000, "R5 mid still ext");
      // R5
      wr_idx(8'h01); wr_dat(8'h01);
      chk_route(20'h80000, "R5 mid base");
      chk_route(20'h9FFFF, "R5 mid top");
      // R6
      chk_route(20'hA0000, "R6 above mid");
      chk_route(20'hFFFFF, "R6 top");
      // R10: upper bits and other registers
      wr_idx(8'h00); wr_dat(8'hFE);
      chk_route(20'h12345, "R10 reg0 upper bits");
      wr_idx(8'h02); wr_dat(8'hFF);
      wr_idx(8'h01); wr_dat(8'h00);
      chk_route(20'h90000, "R10 reg2 no effect");
      chk_route(20'h40000, "R10 low off");

      // Random mix, R1 R2 R3 R4 R5 R6
      for (int n = 0; n < 600; n++) begin
         int op;
         op = $urandom_range(0, 4);
         case (op)
            0: wr_idx((($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 2)) : 8'($urandom)));
            1: wr_dat(8'($urandom));
            2: rd_port(16'h00E1, "R2 random read");
            3: rd_port(16'($urandom_range(16'h00DE, 16'h00E3)), "R3 random port");
            default: chk_route(20'($urandom), "R4 R5 R6 random route");
         endcase
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule